// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in a word-addressed synchronous memory. A requester presents the virtual address, an access-type flag (read or write) and the frame of the root table, using a valid/ready handshake. The walker reads the root-level entry selected by the top ten address bits and checks that entry's valid flag. It then reads the leaf entry selected by the middle ten bits and checks the leaf's present and write-permission flags.

Each walk ends with a single-cycle response. The response carries either the physical address (leaf frame number joined to the 12-bit page offset) together with the leaf's cache-inhibit flag, or one of three fault codes. When a walk succeeds, the walker records the access in the leaf itself. It always sets the accessed flag, and it sets the dirty flag on a write. The leaf is written back only when one of those flags actually changes.

The memory port returns read data in the cycle after a read is issued. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready_o` is high only while no walk is in progress. A request is taken in a cycle where both `req_valid_i` and `req_ready_o` are high. `req_ready_o` is low from the next cycle until the response cycle has passed.
- R2: The first memory access of a walk is a read at word address {root frame, vaddr[31:22]}, where the root frame is the `ptbr_i` value sampled when the request was accepted.
- R3: If bit 0 of the root entry is 0, the walk ends with fault code 2'b01 (table missing). No second read is issued, and no write is made.
- R4: The second read is at word address {root entry[31:12], vaddr[21:12]}.
- R5: If leaf bit 0 (present) is 0, the walk ends with fault code 2'b10 (page absent), and no write is made.
- R6: A write access to a present leaf whose bit 1 (writable) is 0 ends with fault code 2'b11 (protection), and no write is made.
- R7: On success, the fault code is 2'b00, `rsp_paddr_o` = {leaf[31:12], vaddr[11:0]}, and `rsp_nocache_o` = leaf bit 4.
- R8: On success, the leaf is written back to the address of the second read. The written value has bit 2 (accessed) set and, for a write access, bit 3 (dirty) set. All other bits are unchanged.
- R9: If the accessed flag (and, for writes, the dirty flag) is already set, no write is made.
- R10: After reset, `req_ready_o` is 1, and `rsp_valid_o`, `mem_req_o` and `mem_we_o` are 0.
- R11: `rsp_valid_o` is high for exactly one cycle per accepted request.
- R12: A leaf that is both absent and read-only reports fault code 2'b10 on a write, because the present check takes priority over the protection check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptbr_i | input | 20 | Frame of the root table, sampled at accept |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_nocache_o | output | 1 | Cache-inhibit flag of the leaf |
| rsp_fault_o | output | 2 | 00 ok, 01 table missing, 10 page absent, 11 protection |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 30 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read |

## Verification
The bench targets four corner cases:

- **Root entry without its valid flag.** A walker that ignores this flag would issue a bogus second read, so the bench counts memory reads per walk.
- **Flag write-back.** The bench repeats accesses to the same page. This exposes a walker that rewrites a leaf whose flags are already set, one that never sets the dirty flag, and one that clobbers the frame bits.
- **Protection faults.** The bench checks that a denied write leaves the leaf untouched, and that a read of the same read-only page still succeeds.
- **Fault priority.** The bench writes to a leaf that is both absent and read-only. A walker with the present and protection checks swapped would report the wrong code here.

A second root frame is also used, to catch address concatenation that takes the wrong field.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int LEAF_PRESENT = 0;
  localparam int LEAF_WRITE   = 1;
  localparam int LEAF_ACCESS  = 2;
  localparam int LEAF_DIRTY   = 3;
  localparam int LEAF_NOCACHE = 4;
  localparam int ROOT_VALID   = 0;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_NO_TABLE = 2'b01,
    FLT_ABSENT   = 2'b10,
    FLT_PROT     = 2'b11
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_READ, ST_L2_READ, ST_WRITEBACK, ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_req_reg.sv
module ptw_req_reg #(
  parameter int VA_W    = 32,
  parameter int FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic               write_i,
  input  logic [FRAME_W-1:0] root_i,
  output logic [VA_W-1:0]    vaddr_o,
  output logic               write_o,
  output logic [FRAME_W-1:0] root_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_o <= '0;
      write_o <= 1'b0;
      root_o  <= '0;
    end else if (load_i) begin
      vaddr_o <= vaddr_i;
      write_o <= write_i;
      root_o  <= root_i;
    end
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] leaf_i,
  input  logic             write_i,
  output fault_e           fault_o,
  output logic [PTE_W-1:0] upd_o,
  output logic             need_wb_o
);
  always_comb begin
    upd_o = leaf_i;
    upd_o[LEAF_ACCESS] = 1'b1;
    if (write_i) upd_o[LEAF_DIRTY] = 1'b1;
    // present check outranks protection
    if (!leaf_i[LEAF_PRESENT])                fault_o = FLT_ABSENT;
    else if (write_i && !leaf_i[LEAF_WRITE])  fault_o = FLT_PROT;
    else                                      fault_o = FLT_NONE;
    need_wb_o = (fault_o == FLT_NONE) && (upd_o != leaf_i);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PTE_W = 32,
  localparam int FRAME_W = VA_W - OFF_W,
  localparam int WA_W    = FRAME_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] ptbr_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               req_write_i,
  output logic               rsp_valid_o,
  output logic [VA_W-1:0]    rsp_paddr_o,
  output logic               rsp_nocache_o,
  output logic [1:0]         rsp_fault_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [WA_W-1:0]    mem_addr_o,
  output logic [PTE_W-1:0]   mem_wdata_o,
  input  logic [PTE_W-1:0]   mem_rdata_i
);
  walk_state_e state_q, state_d;
  logic issued_q;
  logic [FRAME_W-1:0] l2_base_q, root_q;
  logic [PTE_W-1:0] upd_q;
  logic [VA_W-1:0] va_q, paddr_q;
  logic write_q, nocache_q;
  fault_e fault_q;

  logic accept;
  fault_e leaf_fault;
  logic [PTE_W-1:0] leaf_upd;
  logic leaf_wb;
  logic [IDX_W-1:0] l1_idx, l2_idx;

  assign accept = req_valid_i && req_ready_o;
  assign l1_idx = va_q[VA_W-1 -: IDX_W];
  assign l2_idx = va_q[OFF_W +: IDX_W];

  ptw_req_reg #(.VA_W(VA_W), .FRAME_W(FRAME_W)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .vaddr_i(req_vaddr_i), .write_i(req_write_i), .root_i(ptbr_i),
    .vaddr_o(va_q), .write_o(write_q), .root_o(root_q)
  );

  ptw_leaf_eval #(.PTE_W(PTE_W)) u_leaf (
    .leaf_i(mem_rdata_i), .write_i(write_q),
    .fault_o(leaf_fault), .upd_o(leaf_upd), .need_wb_o(leaf_wb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = ST_L1_READ;
      ST_L1_READ:   if (issued_q)
                      state_d = mem_rdata_i[ROOT_VALID] ? ST_L2_READ : ST_DONE;
      ST_L2_READ:   if (issued_q)
                      state_d = leaf_wb ? ST_WRITEBACK : ST_DONE;
      ST_WRITEBACK: state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      issued_q  <= 1'b0;
      l2_base_q <= '0;
      upd_q     <= '0;
      paddr_q   <= '0;
      nocache_q <= 1'b0;
      fault_q   <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_L1_READ || state_q == ST_L2_READ) issued_q <= !issued_q;
      else issued_q <= 1'b0;
      if (state_q == ST_L1_READ && issued_q) begin
        l2_base_q <= mem_rdata_i[PTE_W-1 -: FRAME_W];
        paddr_q   <= '0;
        nocache_q <= 1'b0;
        fault_q   <= mem_rdata_i[ROOT_VALID] ? FLT_NONE : FLT_NO_TABLE;
      end
      if (state_q == ST_L2_READ && issued_q) begin
        upd_q   <= leaf_upd;
        fault_q <= leaf_fault;
        if (leaf_fault == FLT_NONE) begin
          paddr_q   <= {mem_rdata_i[PTE_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
          nocache_q <= mem_rdata_i[LEAF_NOCACHE];
        end
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {l2_base_q, l2_idx};
    mem_wdata_o = upd_q;
    unique case (state_q)
      ST_L1_READ: begin
        mem_req_o  = !issued_q;
        mem_addr_o = {root_q, l1_idx};
      end
      ST_L2_READ:   mem_req_o = !issued_q;
      ST_WRITEBACK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = (state_q == ST_DONE);
  assign rsp_paddr_o   = paddr_q;
  assign rsp_nocache_o = nocache_q;
  assign rsp_fault_o   = fault_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_fault_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PTE_W-1:0] mem_wdata_o
);
  p_busy_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));

  p_no_table_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'b01) |-> !$past(mem_req_o));

  p_write_only_success_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (rsp_valid_o && rsp_fault_o == 2'b00));

  p_write_sets_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && mem_wdata_o[LEAF_ACCESS] && mem_wdata_o[LEAF_PRESENT]));

  p_rsp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind ptw_walker ptw_walker_chk #(.PTE_W(PTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_fault_o(rsp_fault_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [19:0] ptbr;
  logic req_valid, req_ready, req_write;
  logic [31:0] req_vaddr;
  logic rsp_valid, rsp_nocache;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_ni), .ptbr_i(ptbr),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_nocache_o(rsp_nocache), .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  int vectors = 0, errors = 0, done_cnt = 0;

  logic [31:0] mem [logic [29:0]];
  int n_rd, n_wr;
  logic [29:0] rd0, rd1, wr_addr;
  logic [31:0] wr_data;

  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      n_rd <= 0; n_wr <= 0;
    end
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        n_wr <= n_wr + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        if (n_rd == 0) rd0 <= mem_addr; else rd1 <= mem_addr;
        n_rd <= n_rd + 1;
      end
    end
  end

  typedef struct {
    string       req;
    logic [1:0]  fault;
    logic [31:0] paddr;
    logic        nc;
    int          reads;
    logic [29:0] a0, a1;
    int          writes;
    logic [31:0] wdata;
  } exp_t;
  exp_t sb[$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && rsp_valid) begin
      if (sb.size() == 0) check("R11", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " fault"}, rsp_fault, e.fault);
        check({e.req, " paddr R7"}, rsp_paddr, e.paddr);
        check({e.req, " nocache R7"}, rsp_nocache, e.nc);
        check({e.req, " reads R3"}, n_rd, e.reads);
        check({e.req, " l1 addr R2"}, rd0, e.a0);
        if (e.reads > 1) check({e.req, " l2 addr R4"}, rd1, e.a1);
        check({e.req, " writes R9"}, n_wr, e.writes);
        if (e.writes > 0) begin
          check({e.req, " wb addr R8"}, wr_addr, e.a1);
          check({e.req, " wb data R8"}, wr_data, e.wdata);
        end
      end
      done_cnt++;
    end
  end

  task automatic walk(string req, logic [19:0] root, logic [31:0] va, logic wr,
                      logic [1:0] f, logic [31:0] pa, logic nc, int rds,
                      int wrs, logic [31:0] wd);
    exp_t e;
    int target;
    e.req = req; e.fault = f; e.paddr = pa; e.nc = nc; e.reads = rds;
    e.a0 = {root, va[31:22]};
    e.a1 = (mem.exists(e.a0) ? {mem[e.a0][31:12], va[21:12]} : 30'h0);
    e.writes = wrs; e.wdata = wd;
    sb.push_back(e);
    target = done_cnt + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ptbr = root; req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 busy", req_ready, 0);
    wait (done_cnt == target);
    @(negedge clk);
    check("R1 ready after rsp", req_ready, 1);
    check("R11 single pulse", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  localparam logic [19:0] ROOT_A = 20'h00100;
  localparam logic [19:0] ROOT_B = 20'h00300;
  function automatic logic [31:0] va_of(int i1, int i2, int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  initial begin
    req_valid = 0; req_write = 0; req_vaddr = '0; ptbr = '0;
    mem[{ROOT_A, 10'd3}] = 32'h0020_0001;
    mem[{20'h00200, 10'd5}] = 32'h1234_5013;
    mem[{20'h00200, 10'd6}] = 32'h0005_5002;
    mem[{20'h00200, 10'd8}] = 32'h0006_6001;
    mem[{20'h00200, 10'd9}] = 32'h0007_7000;
    mem[{ROOT_B, 10'd3}] = 32'h0040_0001;
    mem[{20'h00400, 10'd5}] = 32'h0ABC_D019;
    repeat (3) @(negedge clk);
    check("R10 ready", req_ready, 1);
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 mem_req", mem_req, 0);
    check("R10 mem_we", mem_we, 0);
    rst_ni = 1'b1;

    walk("R7 read ok",      ROOT_A, va_of(3,5,'habc), 0, 2'b00, 32'h1234_5abc, 1, 2, 1, 32'h1234_5017);
    walk("R8 write dirty",  ROOT_A, va_of(3,5,'h004), 1, 2'b00, 32'h1234_5004, 1, 2, 1, 32'h1234_501F);
    walk("R9 read no wb",   ROOT_A, va_of(3,5,'hfff), 0, 2'b00, 32'h1234_5fff, 1, 2, 0, 0);
    walk("R9 write no wb",  ROOT_A, va_of(3,5,'h000), 1, 2'b00, 32'h1234_5000, 1, 2, 0, 0);
    walk("R3 no table",     ROOT_A, va_of(7,5,'h010), 0, 2'b01, 32'h0, 0, 1, 0, 0);
    walk("R5 absent",       ROOT_A, va_of(3,6,'h020), 0, 2'b10, 32'h0, 0, 2, 0, 0);
    walk("R6 prot",         ROOT_A, va_of(3,8,'h030), 1, 2'b11, 32'h0, 0, 2, 0, 0);
    check("R6 leaf intact", mem[{20'h00200, 10'd8}], 32'h0006_6001);
    walk("R6 ro read ok",   ROOT_A, va_of(3,8,'h040), 0, 2'b00, 32'h0006_6040, 0, 2, 1, 32'h0006_6005);
    walk("R12 priority",    ROOT_A, va_of(3,9,'h050), 1, 2'b10, 32'h0, 0, 2, 0, 0);
    walk("R2 other root",   ROOT_B, va_of(3,5,'h123), 0, 2'b00, 32'h0ABC_D123, 1, 2, 1, 32'h0ABC_D01D);
    walk("R4 other root ro",ROOT_B, va_of(3,5,'h124), 1, 2'b11, 32'h0, 0, 2, 0, 0);

    check("R11 all responded", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule